// File: doc/BRIEF.md
# I/Q Line-Code Decoder

This block turns hard decisions taken on the I and Q rails into a single stream of data bits. Samples arrive at twice the symbol rate. Each one is flagged by a one-cycle strobe, and two consecutive strobes on a rail make up one symbol. A three-bit select chooses how a symbol is read:

- plain level;
- mark-differential, where a change of level means one;
- space-differential, where no change of level means one;
- split-phase, where each symbol is a pair of opposite half levels.

In the split-phase code, a pair of equal halves is reported as a code violation alongside the bit.

When interleaving is off, only the I rail is decoded and delivered. When it is on, the two rails are assumed to run at one common symbol rate, and the output alternates I, Q, I, Q, starting with I. A further switch tells the block that Q symbols straddle the I symbol boundaries by half a symbol. The Q rail then drops its very first half sample after reset, so that its later pairs line up with whole Q symbols.

Each rail feeds a small queue. A registered merge stage pops the queues in the required order, so bits that complete on both rails in the same cycle leave the block on consecutive cycles.

Top module: `lcd_iq_decoder`

## Requirements
- R1: A synchronous reset clears the outputs `dec_vld` and `dec_viol` to 0, sets the half-sample phase of each rail to "first half", and clears each rail's remembered previous level to 0.
- R2: A symbol is formed by two consecutive accepted strobes on a rail, and its level is the first of the two samples. With `cfg_code` = 0 the decoded bit equals that level.
- R3: With `cfg_code` = 1 the decoded bit is 1 when the symbol level differs from the previous symbol level on the same rail, and 0 otherwise.
- R4: With `cfg_code` = 2 the decoded bit is 1 when the symbol level equals the previous symbol level on the same rail, and 0 otherwise.
- R5: With `cfg_code` = 4, halves of high then low decode to 1 and halves of low then high decode to 0. Equal halves give the first-half value with `dec_viol` = 1. `dec_viol` is never set under any other code.
- R6: `cfg_code` values 3, 5, 6 and 7 decode exactly like value 0.
- R7: With `cfg_ilv` = 1, successive output bits alternate between the rails, starting with I after reset, and no bit is lost when both rails complete a symbol in the same cycle.
- R8: With `cfg_qoff` = 1 and `cfg_ilv` = 1, the first Q strobe after reset is discarded, and Q symbols are then formed from the following pairs of strobes.
- R9: With `cfg_ilv` = 0, Q strobes and samples have no effect: the output carries only the I bits.
- R10: `dec_vld` is high for exactly one cycle per decoded bit, and `dec_viol` is high only together with `dec_vld`.
- R11: Each rail keeps its own previous level for the differential codes. Q symbols never alter the I reference, and I symbols never alter the Q reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_code | input | 3 | Line code select (0 level, 1 mark-diff, 2 space-diff, 4 split-phase, others as 0) |
| cfg_ilv | input | 1 | 1 = interleave I and Q into the output |
| cfg_qoff | input | 1 | 1 = Q rail lags I by half a symbol |
| i_stb | input | 1 | I half-sample strobe |
| i_smp | input | 1 | I hard decision |
| q_stb | input | 1 | Q half-sample strobe |
| q_smp | input | 1 | Q hard decision |
| dec_bit | output | 1 | Decoded data bit |
| dec_vld | output | 1 | One-cycle strobe for `dec_bit` |
| dec_viol | output | 1 | Split-phase code violation on this bit |

## Verification
The bench targets the following corner cases:

- **Symbol order under interleaving.** Both rails finish a symbol in the same cycle. A merge that pops both rails at once would drop the Q bit or emit Q first.
- **Half-symbol Q offset.** If the discarded first Q sample were kept, every Q bit would be built from halves of two neighbouring symbols.
- **Per-rail differential memory.** Differential runs use different I and Q patterns, so a shared previous-level register would corrupt both streams.
- **Split-phase violations and unused codes.** Split-phase runs contain equal-half symbols, and runs with unused code values must match the plain-level result.
- **Q with interleaving off.** A run with interleaving off toggles Q throughout and must still yield only the four I bits.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [2:0] {
    CODE_LEVEL = 3'd0,
    CODE_MARK  = 3'd1,
    CODE_SPACE = 3'd2,
    CODE_SPLIT = 3'd4
  } lcd_code_e;

  typedef struct packed {
    logic viol;
    logic bitv;
  } lcd_sym_t;

  localparam int SYM_W = $bits(lcd_sym_t);

  // Decode one symbol from its two halves and the previous level.
  function automatic lcd_sym_t lcd_decode(input logic [2:0] code,
                                          input logic h0,
                                          input logic h1,
                                          input logic prev);
    lcd_sym_t s;
    s.viol = 1'b0;
    s.bitv = h0;
    case (code)
      CODE_MARK:  s.bitv = h0 ^ prev;
      CODE_SPACE: s.bitv = ~(h0 ^ prev);
      CODE_SPLIT: s.viol = (h0 == h1);
      default:    s.bitv = h0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_chan_dec.sv
module lcd_chan_dec
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       skip_first,
  input  logic       stb,
  input  logic       smp,
  input  logic [2:0] code,
  output logic       sym_vld,
  output lcd_sym_t   sym
);

  logic phase;   // 0 = expecting first half
  logic half0;
  logic prev;
  logic primed;  // no strobe accepted yet since reset

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      half0   <= 1'b0;
      prev    <= 1'b0;
      primed  <= 1'b1;
      sym_vld <= 1'b0;
      sym     <= '0;
    end else begin
      sym_vld <= 1'b0;
      if (en && stb) begin
        primed <= 1'b0;
        if (primed && skip_first) begin
          phase <= 1'b0;
        end else if (!phase) begin
          half0 <= smp;
          phase <= 1'b1;
        end else begin
          phase   <= 1'b0;
          sym     <= lcd_decode(code, half0, smp, prev);
          sym_vld <= 1'b1;
          prev    <= half0;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_sym_fifo.sv
module lcd_sym_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         nempty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  assign nempty = (cnt != '0);
  assign full   = (cnt == (AW+1)'(DEPTH));
  assign wr_ok  = push && !full;
  assign rd_ok  = pop && nempty;
  assign rdata  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/lcd_iq_decoder.sv
module lcd_iq_decoder
  import lcd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cfg_code,
  input  logic       cfg_ilv,
  input  logic       cfg_qoff,
  input  logic       i_stb,
  input  logic       i_smp,
  input  logic       q_stb,
  input  logic       q_smp,
  output logic       dec_bit,
  output logic       dec_vld,
  output logic       dec_viol
);

  localparam int NCH = 2;  // index 0 = I, 1 = Q

  logic [NCH-1:0] ch_en, ch_skip, ch_stb, ch_smp;
  logic [NCH-1:0] sym_vld, sym_viol, push, full, nempty, pop;
  lcd_sym_t       sym  [NCH];
  lcd_sym_t       head [NCH];

  assign ch_en   = {cfg_ilv, 1'b1};
  assign ch_skip = {cfg_qoff, 1'b0};
  assign ch_stb  = {q_stb, i_stb};
  assign ch_smp  = {q_smp, i_smp};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SYM_W-1:0] rd;

    lcd_chan_dec u_dec (
      .clk        (clk),
      .rst        (rst),
      .en         (ch_en[g]),
      .skip_first (ch_skip[g]),
      .stb        (ch_stb[g]),
      .smp        (ch_smp[g]),
      .code       (cfg_code),
      .sym_vld    (sym_vld[g]),
      .sym        (sym[g])
    );

    assign push[g]     = sym_vld[g];
    assign sym_viol[g] = sym[g].viol;

    lcd_sym_fifo #(.W(SYM_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk    (clk),
      .rst    (rst),
      .push   (push[g]),
      .wdata  (sym[g]),
      .pop    (pop[g]),
      .rdata  (rd),
      .nempty (nempty[g]),
      .full   (full[g])
    );

    assign head[g] = lcd_sym_t'(rd);
  end

  // Merge stage: I first, then Q, when interleaving.
  logic turn_q;
  logic src_q;

  always_comb begin
    pop[0] = nempty[0] && (!cfg_ilv || !turn_q);
    pop[1] = nempty[1] && cfg_ilv && turn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q   <= 1'b0;
      src_q    <= 1'b0;
      dec_vld  <= 1'b0;
      dec_bit  <= 1'b0;
      dec_viol <= 1'b0;
    end else begin
      dec_vld  <= |pop;
      src_q    <= pop[1];
      dec_bit  <= pop[1] ? head[1].bitv : (pop[0] & head[0].bitv);
      dec_viol <= pop[1] ? head[1].viol : (pop[0] & head[0].viol);
      if (!cfg_ilv)    turn_q <= 1'b0;
      else if (pop[0]) turn_q <= 1'b1;
      else if (pop[1]) turn_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_iq_decoder_chk.sv
module lcd_iq_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_code,
  input logic       cfg_ilv,
  input logic       dec_vld,
  input logic       dec_viol,
  input logic       src_q,
  input logic [1:0] sym_vld,
  input logic [1:0] sym_viol,
  input logic [1:0] push,
  input logic [1:0] full
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= 1'b0;
    else if (dec_vld) last_q <= src_q;
  end

  // R5: a violation only comes from a symbol decoded under the split-phase code
  a_r5_viol_only_split_i: assert property (@(posedge clk) disable iff (rst)
    (sym_vld[0] && sym_viol[0]) |-> ($past(cfg_code) == 3'd4));
  a_r5_viol_only_split_q: assert property (@(posedge clk) disable iff (rst)
    (sym_vld[1] && sym_viol[1]) |-> ($past(cfg_code) == 3'd4));

  // R10: the violation flag never stands without a valid bit
  a_r10_viol_with_vld: assert property (@(posedge clk) disable iff (rst)
    dec_viol |-> dec_vld);

  // R7: two Q bits never leave back to back
  a_r7_no_double_q: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && src_q) |-> !last_q);

  // R9: a Q bit leaves only when interleaving was selected
  a_r9_q_only_ilv: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && src_q) |-> $past(cfg_ilv));

  // R7: equal rates never overfill a rail queue
  a_r7_no_overflow_i: assert property (@(posedge clk) disable iff (rst)
    push[0] |-> !full[0]);
  a_r7_no_overflow_q: assert property (@(posedge clk) disable iff (rst)
    push[1] |-> !full[1]);

endmodule

bind lcd_iq_decoder lcd_iq_decoder_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_code (cfg_code),
  .cfg_ilv  (cfg_ilv),
  .dec_vld  (dec_vld),
  .dec_viol (dec_viol),
  .src_q    (src_q),
  .sym_vld  (sym_vld),
  .sym_viol (sym_viol),
  .push     (push),
  .full     (full)
);

// File: tb/lcd_iq_decoder_tb_top.sv
module lcd_iq_decoder_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 12;

  typedef struct packed {
    logic [2:0] code;
    logic       ilv;
    logic       qoff;
    logic [7:0] ipat;   // bit k = k-th I half sample
    logic [8:0] qpat;   // bit k = k-th Q half sample
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 8'h96, 9'h000},  // R2 level
    '{3'd1, 1'b0, 1'b0, 8'hB3, 9'h000},  // R3 mark-diff
    '{3'd2, 1'b0, 1'b0, 8'hB3, 9'h000},  // R4 space-diff
    '{3'd4, 1'b0, 1'b0, 8'h59, 9'h000},  // R5 clean split-phase
    '{3'd4, 1'b0, 1'b0, 8'h93, 9'h000},  // R5 violations
    '{3'd5, 1'b0, 1'b0, 8'hC5, 9'h000},  // R6 unused code
    '{3'd7, 1'b0, 1'b0, 8'h3A, 9'h000},  // R6 unused code
    '{3'd0, 1'b1, 1'b0, 8'h96, 9'h0C3},  // R7 interleave
    '{3'd1, 1'b1, 1'b0, 8'h33, 9'h0F0},  // R11 separate refs
    '{3'd0, 1'b1, 1'b1, 8'hA5, 9'h15B},  // R8 offset
    '{3'd2, 1'b0, 1'b0, 8'h4E, 9'h1FF},  // R9 Q ignored
    '{3'd4, 1'b1, 1'b1, 8'h66, 9'h0D3}   // R8 offset split-phase
  };

  function automatic string tag_of(input int n);
    case (n)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8: return "R11";
      9, 11: return "R8";
      default: return "R9";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_code = '0;
  logic       cfg_ilv = 1'b0, cfg_qoff = 1'b0;
  logic       i_stb = 1'b0, i_smp = 1'b0, q_stb = 1'b0, q_smp = 1'b0;
  logic       dec_bit, dec_vld, dec_viol;

  int n_chk = 0, n_fail = 0, stray = 0;
  bit done = 0;

  logic       got_bit [16];
  logic       got_viol[16];
  int         got_n = 0;
  bit         collect = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_iq_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_code(cfg_code), .cfg_ilv(cfg_ilv),
    .cfg_qoff(cfg_qoff), .i_stb(i_stb), .i_smp(i_smp), .q_stb(q_stb),
    .q_smp(q_smp), .dec_bit(dec_bit), .dec_vld(dec_vld), .dec_viol(dec_viol)
  );

  always @(negedge clk) begin
    if (!rst && dec_viol && !dec_vld) stray++;
    if (collect && dec_vld && got_n < 16) begin
      got_bit[got_n]  = dec_bit;
      got_viol[got_n] = dec_viol;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic model(input logic [2:0] code, input logic [8:0] pat,
                       input logic off, output logic [3:0] b,
                       output logic [3:0] v);
    logic prev, h0, h1;
    int base;
    prev = 1'b0;
    base = off ? 1 : 0;
    for (int s = 0; s < 4; s++) begin
      h0 = pat[base + 2*s];
      h1 = pat[base + 2*s + 1];
      v[s] = 1'b0;
      case (code)
        3'd1: b[s] = h0 ^ prev;
        3'd2: b[s] = ~(h0 ^ prev);
        3'd4: begin b[s] = h0; v[s] = (h0 == h1); end
        default: b[s] = h0;
      endcase
      prev = h0;
    end
  endtask

  task automatic drive(input vec_t v);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      i_stb = (k < 8);
      i_smp = v.ipat[k % 8];
      q_stb = (k < 8) || v.qoff;
      q_smp = v.qpat[k];
      @(negedge clk);
      i_stb = 1'b0;
      q_stb = 1'b0;
    end
  endtask

  task automatic run_vec(input int n);
    vec_t v;
    logic [3:0] ib, iv, qb, qv;
    logic eb [8];
    logic ev [8];
    int ne;
    string tag;
    v = VECS[n];
    tag = tag_of(n);
    cfg_code = v.code;
    cfg_ilv  = v.ilv;
    cfg_qoff = v.qoff;
    do_reset();
    got_n = 0;
    collect = 1;
    drive(v);
    repeat (12) @(negedge clk);
    collect = 0;
    model(v.code, {1'b0, v.ipat}, 1'b0, ib, iv);
    model(v.code, v.qpat, v.qoff, qb, qv);
    ne = v.ilv ? 8 : 4;
    for (int s = 0; s < 4; s++) begin
      if (v.ilv) begin
        eb[2*s] = ib[s]; ev[2*s] = iv[s];
        eb[2*s+1] = qb[s]; ev[2*s+1] = qv[s];
      end else begin
        eb[s] = ib[s]; ev[s] = iv[s];
      end
    end
    check(got_n == ne, tag, $sformatf("vec %0d bit count", n), got_n, ne);
    for (int j = 0; j < ne && j < got_n; j++) begin
      check(got_bit[j] == eb[j], tag, $sformatf("vec %0d bit %0d", n, j),
            int'(got_bit[j]), int'(eb[j]));
      check(got_viol[j] == ev[j], tag, $sformatf("vec %0d viol %0d", n, j),
            int'(got_viol[j]), int'(ev[j]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: outputs idle after reset
    check(dec_vld == 1'b0, "R1", "dec_vld after reset", int'(dec_vld), 0);
    check(dec_viol == 1'b0, "R1", "dec_viol after reset", int'(dec_viol), 0);

    for (int n = 0; n < NV; n++) run_vec(n);

    // R1: reset mid-run, then mark-diff must restart from level 0
    cfg_code = 3'd1; cfg_ilv = 1'b0; cfg_qoff = 1'b0;
    @(negedge clk); i_stb = 1'b1; i_smp = 1'b1;
    @(negedge clk); i_stb = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(dec_vld == 1'b0, "R1", "dec_vld under reset", int'(dec_vld), 0);
    rst = 1'b0;
    got_n = 0; collect = 1;
    @(negedge clk); i_stb = 1'b1; i_smp = 1'b1;
    @(negedge clk); i_stb = 1'b0;
    @(negedge clk); i_stb = 1'b1; i_smp = 1'b0;
    @(negedge clk); i_stb = 1'b0;
    repeat (6) @(negedge clk);
    collect = 0;
    check(got_n == 1, "R1", "bits after reset", got_n, 1);
    check(got_n >= 1 && got_bit[0] == 1'b1, "R1", "mark-diff vs cleared ref",
          int'(got_bit[0]), 1);

    // R10: violation flag never seen without valid
    check(stray == 0, "R10", "stray viol cycles", stray, 0);
    finish_run();
  end

endmodule